// File: doc/BRIEF.md
# Indexed Channel Control Register File

This block holds the per-channel control and status state of a 64-channel DMA controller and exposes it to software through a small word-addressed register port. Five per-channel bit vectors are kept: hardware request enable, error-interrupt enable, interrupt pending, error pending and done. Each vector is read and written as two 32-bit words. The high word covers channels 63 to 32 and the low word covers channels 31 to 0. Beside the wide words there are indexed byte registers. Software writes a channel number to one of them and a single bit of one vector is set or cleared in one write, with no read-modify-write of a shared word.

The transfer engine reports per-channel completion and done events and error events through hardware inputs. The block sets the matching pending bits and holds the first error in a status word until software clears it. It drives a single interrupt line and a one-cycle start strobe per channel. It also drives the request-enable vector and three arbitration configuration bits taken from a control word. Reads are combinational from the registered state.

Top module: `chan_ctl_regs`

## Requirements
- R1: After reset every vector, the control word and the error status word read zero, and `irq`, `start_pulse`, `req_en` and the three configuration outputs are low.
- R2: The request-enable and error-interrupt-enable words load the written value. Channel c is bit c of the low word for c < 32 and bit c-32 of the high word otherwise. Addresses: request-enable high 2, low 3; error-interrupt-enable high 4, low 5.
- R3: A write to address 6 (set request enable), 7 (clear request enable), 8 (set error-interrupt enable) or 9 (clear error-interrupt enable) changes only the bit of the channel given by `wr_data[5:0]`. The upper data bits are ignored.
- R4: A write to address 10 clears the interrupt pending bit, address 11 the error pending bit and address 13 the done bit of the channel in `wr_data[5:0]`. No other bit changes.
- R5: The interrupt (high 14, low 15), error (high 16, low 17) and done (high 18, low 19) words are write-one-to-clear: ones clear the bit, zeros keep it, and all ones clears the whole word.
- R6: `hw_int_set`, `hw_done_set` and `err_event` (at channel `err_chan`) set their pending bits in the next cycle. A hardware set wins over a software clear of the same bit in the same cycle.
- R7: A write to address 12 makes `start_pulse` carry exactly the bit of the channel in `wr_data[5:0]` for the following single cycle. Otherwise `start_pulse` is zero.
- R8: On `err_event` with no valid error held, the status word (address 1) becomes: bit 31 = 1, bits 13:8 = `err_chan`, bits 15, 14 and 7:0 = the same bits of `err_cause`. All other bits are 0.
- R9: While bit 31 of the status word is set, later error events leave the status word unchanged. They still set the error pending bit of their channel.
- R10: Any write to address 1 clears the status word. An error event in the same cycle is captured in place of the cleared value.
- R11: The control word (address 0) keeps only bits 31, 3 and 2, which drive `cfg_grp_arb_en`, `cfg_grp_rr` and `cfg_ch_rr`. The other bits read 0. Unmapped addresses read 0 and writes to them have no effect.
- R12: `irq` is high when any interrupt pending bit is set, or when any error pending bit is set whose error-interrupt enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Combinational read data |
| hw_int_set | input | 64 | Per-channel interrupt events from the engine |
| hw_done_set | input | 64 | Per-channel done events from the engine |
| err_event | input | 1 | Error event strobe |
| err_chan | input | 6 | Channel of the error event |
| err_cause | input | 16 | Error cause bits (15, 14, 7:0 used) |
| req_en | output | 64 | Hardware request enable vector |
| start_pulse | output | 64 | One-cycle channel start strobes |
| cfg_grp_arb_en | output | 1 | Group arbitration enable |
| cfg_grp_rr | output | 1 | Round-robin group arbitration |
| cfg_ch_rr | output | 1 | Round-robin channel arbitration |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench goes after the channel 31/32 boundary between the low and high words. A design that swapped halves or shifted the high word by one would move set and clear hits to the wrong channel. It drives hardware events in the same cycle as software clears of the same bit, where a design with the wrong precedence loses a completion. It sends error events while an error is held and together with a status clear, where a design that overwrites the held error, or drops the event, would show a different channel or cause. It also writes index values with upper bits set and checks the interrupt line with error bits both enabled and masked. A design that used the full byte or ignored the mask would hit the wrong channel or raise a false interrupt.

// File: rtl/chctl_pkg.sv
package chctl_pkg;
    localparam logic [4:0] AD_CTRL      = 5'd0;
    localparam logic [4:0] AD_ESTAT     = 5'd1;
    localparam logic [4:0] AD_SET_START = 5'd12;

    // vector kinds: 0 req enable, 1 err-irq enable, 2 int, 3 err, 4 done
    localparam int NKIND = 5;
    localparam logic [4:0] HI_ADDR  [NKIND] = '{5'd2, 5'd4, 5'd14, 5'd16, 5'd18};
    localparam logic [4:0] LO_ADDR  [NKIND] = '{5'd3, 5'd5, 5'd15, 5'd17, 5'd19};
    localparam logic [4:0] SET_ADDR [NKIND] = '{5'd6, 5'd8, 5'd0, 5'd0, 5'd0};
    localparam logic [4:0] CLR_ADDR [NKIND] = '{5'd7, 5'd9, 5'd10, 5'd11, 5'd13};
    localparam logic [NKIND-1:0] HAS_SET = 5'b00011;

    localparam int CTL_GRP_EN = 31;
    localparam int CTL_GRP_RR = 3;
    localparam int CTL_CH_RR  = 2;

    localparam logic [15:0] CAUSE_MASK = 16'hC0FF;

    typedef struct packed {
        logic grp_en;
        logic grp_rr;
        logic ch_rr;
    } ctl_t;
endpackage

// File: rtl/chctl_vec.sv
module chctl_vec #(
    parameter int NCH   = 64,
    parameter int IDX_W = 6,
    parameter bit W1C   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [NCH-1:0]   hw_set,
    output logic [NCH-1:0]   vec
);
    localparam int HI_W = NCH - 32;

    typedef struct packed {
        logic [NCH-1:0] bits;
    } vec_st_t;

    vec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            if (W1C) st_d.bits[31:0] = st_q.bits[31:0] & ~wdata;
            else     st_d.bits[31:0] = wdata;
        end
        if (wr_hi) begin
            if (W1C) st_d.bits[NCH-1:32] = st_q.bits[NCH-1:32] & ~wdata[HI_W-1:0];
            else     st_d.bits[NCH-1:32] = wdata[HI_W-1:0];
        end
        if (set_en && int'(idx) < NCH) st_d.bits[idx] = 1'b1;
        if (clr_en && int'(idx) < NCH) st_d.bits[idx] = 1'b0;
        // engine events win over any software clear in the same cycle
        st_d.bits = st_d.bits | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec = st_q.bits;
endmodule

// File: rtl/chctl_errcap.sv
module chctl_errcap #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic [IDX_W-1:0] chan,
    input  logic [15:0]      cause,
    input  logic             clr,
    output logic [31:0]      stat
);
    import chctl_pkg::*;

    typedef struct packed {
        logic [31:0] word;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    held;

    always_comb begin
        st_d = st_q;
        held = st_q.word[31] && !clr;
        if (clr) st_d.word = '0;
        if (ev && !held) begin
            st_d.word = {16'h8000, cause & CAUSE_MASK};
            st_d.word[8 +: IDX_W] = chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.word;
endmodule

// File: rtl/chan_ctl_regs.sv
module chan_ctl_regs #(
    parameter int NCH   = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [4:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic [NCH-1:0]   hw_int_set,
    input  logic [NCH-1:0]   hw_done_set,
    input  logic             err_event,
    input  logic [IDX_W-1:0] err_chan,
    input  logic [15:0]      err_cause,
    output logic [NCH-1:0]   req_en,
    output logic [NCH-1:0]   start_pulse,
    output logic             cfg_grp_arb_en,
    output logic             cfg_grp_rr,
    output logic             cfg_ch_rr,
    output logic             irq
);
    import chctl_pkg::*;

    localparam int HI_W = NCH - 32;

    typedef struct packed {
        ctl_t           ctl;
        logic [NCH-1:0] start;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [IDX_W-1:0] w_idx;
    logic [NCH-1:0]   err_hit;
    logic [NCH-1:0]   hw_in [NKIND];
    logic [NCH-1:0]   vec   [NKIND];
    logic [31:0]      err_stat;
    logic [NCH-1:0]   done_vec;

    assign w_idx = wr_data[IDX_W-1:0];

    always_comb begin
        err_hit = '0;
        if (err_event && int'(err_chan) < NCH) err_hit[err_chan] = 1'b1;
        hw_in[0] = '0;
        hw_in[1] = '0;
        hw_in[2] = hw_int_set;
        hw_in[3] = err_hit;
        hw_in[4] = hw_done_set;
    end

    for (genvar g = 0; g < NKIND; g++) begin : g_vec
        chctl_vec #(
            .NCH   (NCH),
            .IDX_W (IDX_W),
            .W1C   (g >= 2)
        ) u_vec (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_lo  (wr_en && wr_addr == LO_ADDR[g]),
            .wr_hi  (wr_en && wr_addr == HI_ADDR[g]),
            .wdata  (wr_data),
            .set_en (HAS_SET[g] && wr_en && wr_addr == SET_ADDR[g]),
            .clr_en (wr_en && wr_addr == CLR_ADDR[g]),
            .idx    (w_idx),
            .hw_set (hw_in[g]),
            .vec    (vec[g])
        );
    end

    chctl_errcap #(.IDX_W(IDX_W)) u_errcap (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (err_event),
        .chan  (err_chan),
        .cause (err_cause),
        .clr   (wr_en && wr_addr == AD_ESTAT),
        .stat  (err_stat)
    );

    always_comb begin
        st_d = st_q;
        st_d.start = '0;
        if (wr_en && wr_addr == AD_CTRL) begin
            st_d.ctl.grp_en = wr_data[CTL_GRP_EN];
            st_d.ctl.grp_rr = wr_data[CTL_GRP_RR];
            st_d.ctl.ch_rr  = wr_data[CTL_CH_RR];
        end
        if (wr_en && wr_addr == AD_SET_START && int'(w_idx) < NCH)
            st_d.start[w_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AD_CTRL) begin
            rd_data[CTL_GRP_EN] = st_q.ctl.grp_en;
            rd_data[CTL_GRP_RR] = st_q.ctl.grp_rr;
            rd_data[CTL_CH_RR]  = st_q.ctl.ch_rr;
        end
        if (rd_addr == AD_ESTAT) rd_data = err_stat;
        for (int k = 0; k < NKIND; k++) begin
            if (rd_addr == LO_ADDR[k]) rd_data = vec[k][31:0];
            if (rd_addr == HI_ADDR[k]) rd_data = {{(32-HI_W){1'b0}}, vec[k][NCH-1:32]};
        end
    end

    assign done_vec       = vec[4];
    assign req_en         = vec[0];
    assign start_pulse    = st_q.start;
    assign cfg_grp_arb_en = st_q.ctl.grp_en;
    assign cfg_grp_rr     = st_q.ctl.grp_rr;
    assign cfg_ch_rr      = st_q.ctl.ch_rr;
    assign irq            = (|vec[2]) | (|(vec[3] & vec[1]));
endmodule

// File: rtl/chctl_check.sv
module chctl_check #(
    parameter int NCH = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [4:0]     wr_addr,
    input logic [NCH-1:0] hw_done_set,
    input logic [NCH-1:0] hw_int_set,
    input logic [NCH-1:0] done_vec,
    input logic [NCH-1:0] start_pulse,
    input logic           err_event,
    input logic [31:0]    err_stat,
    input logic           irq
);
    import chctl_pkg::*;

    assert_done_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_vec & $past(hw_done_set)) == $past(hw_done_set)));

    assert_start_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_pulse));

    assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse != '0) |-> $past(wr_en && wr_addr == AD_SET_START));

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_event && !err_stat[31]) |-> err_stat[31]);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_stat[31]) && !$past(wr_en && wr_addr == AD_ESTAT)) |-> $stable(err_stat));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_addr == AD_ESTAT && !err_event) |-> !err_stat[31]);

    assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_en || err_event || (|hw_int_set)));
endmodule

bind chan_ctl_regs chctl_check #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .hw_done_set (hw_done_set),
    .hw_int_set  (hw_int_set),
    .done_vec    (done_vec),
    .start_pulse (start_pulse),
    .err_event   (err_event),
    .err_stat    (err_stat),
    .irq         (irq)
);

// File: tb/sim_chan_ctl_regs.sv
`timescale 1ns/1ps
module sim_chan_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] hw_int_set = '0;
    logic [63:0] hw_done_set = '0;
    logic        err_event = 1'b0;
    logic [5:0]  err_chan = '0;
    logic [15:0] err_cause = '0;
    logic [63:0] req_en, start_pulse;
    logic        cfg_grp_arb_en, cfg_grp_rr, cfg_ch_rr, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // model state: vectors 0 reqen, 1 eie, 2 int, 3 err, 4 done
    logic [63:0] m_vec [5];
    logic [31:0] m_stat;
    logic [2:0]  m_ctl;
    logic [63:0] m_start;

    always #2.5 clk = ~clk;

    chan_ctl_regs u0 (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int a);
        if (a == 0) return "R11";
        if (a == 1) return "R8";
        if (a >= 2 && a <= 5) return "R2";
        if (a >= 14 && a <= 19) return "R5";
        return "R11";
    endfunction

    function automatic logic [31:0] m_read(input int a);
        case (a)
            0: return {m_ctl[2], 27'b0, m_ctl[1], m_ctl[0], 2'b0};
            1: return m_stat;
            2: return m_vec[0][63:32];  3: return m_vec[0][31:0];
            4: return m_vec[1][63:32];  5: return m_vec[1][31:0];
            14: return m_vec[2][63:32]; 15: return m_vec[2][31:0];
            16: return m_vec[3][63:32]; 17: return m_vec[3][31:0];
            18: return m_vec[4][63:32]; 19: return m_vec[4][31:0];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_update(input bit we, input int a, input logic [31:0] d,
                                input logic [63:0] hi, input logic [63:0] hd,
                                input bit ee, input int ec, input logic [15:0] ca);
        int ix;
        bit clr;
        ix = int'(d[5:0]);
        clr = 1'b0;
        m_start = '0;
        if (we) begin
            case (a)
                0: m_ctl = {d[31], d[3], d[2]};
                1: clr = 1'b1;
                2: m_vec[0][63:32] = d;  3: m_vec[0][31:0] = d;
                4: m_vec[1][63:32] = d;  5: m_vec[1][31:0] = d;
                6: m_vec[0][ix] = 1'b1;  7: m_vec[0][ix] = 1'b0;
                8: m_vec[1][ix] = 1'b1;  9: m_vec[1][ix] = 1'b0;
                10: m_vec[2][ix] = 1'b0; 11: m_vec[3][ix] = 1'b0;
                12: m_start[ix] = 1'b1;  13: m_vec[4][ix] = 1'b0;
                14: m_vec[2][63:32] &= ~d; 15: m_vec[2][31:0] &= ~d;
                16: m_vec[3][63:32] &= ~d; 17: m_vec[3][31:0] &= ~d;
                18: m_vec[4][63:32] &= ~d; 19: m_vec[4][31:0] &= ~d;
                default: ;
            endcase
        end
        m_vec[2] |= hi;
        m_vec[4] |= hd;
        if (ee) m_vec[3][ec] = 1'b1;
        if (clr) m_stat = '0;
        if (ee && !m_stat[31])
            m_stat = 32'h8000_0000 | {16'h0, ca & 16'hC0FF} | (32'(ec) << 8);
    endtask

    task automatic compare_all();
        logic m_irq;
        for (int a = 0; a < 22; a++) begin
            rd_addr = 5'(a);
            #0.05;
            check(tag_of(a), {32'h0, rd_data}, {32'h0, m_read(a)});
        end
        m_irq = (|m_vec[2]) | (|(m_vec[3] & m_vec[1]));
        check("R12", {63'h0, irq}, {63'h0, m_irq});
        check("R7", start_pulse, m_start);
        check("R3", req_en, m_vec[0]);
        check("R11", {61'h0, cfg_grp_arb_en, cfg_grp_rr, cfg_ch_rr}, {61'h0, m_ctl});
    endtask

    // one clocked operation, starting from a negedge
    task automatic step(input bit we, input int a, input logic [31:0] d,
                        input logic [63:0] hi, input logic [63:0] hd,
                        input bit ee, input int ec, input logic [15:0] ca);
        wr_en = we; wr_addr = 5'(a); wr_data = d;
        hw_int_set = hi; hw_done_set = hd;
        err_event = ee; err_chan = 6'(ec); err_cause = ca;
        @(posedge clk);
        #1;
        model_update(we, a, d, hi, hd, ee, ec, ca);
        wr_en = 1'b0; hw_int_set = '0; hw_done_set = '0; err_event = 1'b0;
        compare_all();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        step(1'b1, a, d, '0, '0, 1'b0, 0, '0);
    endtask

    task automatic rd_check(input string tag, input int a, input logic [31:0] exp);
        rd_addr = 5'(a);
        #0.05;
        check(tag, {32'h0, rd_data}, {32'h0, exp});
    endtask

    initial begin
        for (int k = 0; k < 5; k++) m_vec[k] = '0;
        m_stat = '0; m_ctl = '0; m_start = '0;
        void'($urandom(32'hC0FFEE));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 22; a++) rd_check("R1", a, 32'h0);
        check("R1", {63'h0, irq}, 64'h0);
        check("R1", start_pulse, 64'h0);

        // R2: word layout
        wr(3, 32'h8000_0001);
        wr(2, 32'h0000_0001);
        check("R2", req_en, 64'h0000_0001_8000_0001);
        // R3: indexed set/clear at the word boundary, upper data bits ignored
        wr(6, 32'h0000_0020);
        wr(7, 32'h0000_001F);
        wr(7, 32'hFFFF_FFE0);
        wr(6, 32'h0000_00C5);
        check("R3", req_en, 64'h0000_0000_0000_0021);
        wr(8, 32'd63);
        rd_check("R3", 4, 32'h8000_0000);
        // R6/R4: engine events and indexed clears, including a collision
        step(1'b0, 0, 0, 64'h0000_0100_0000_0000, 64'h80, 1'b0, 0, '0);
        wr(10, 32'd40);
        rd_check("R4", 14, 32'h0);
        step(1'b1, 13, 32'd7, '0, 64'h80, 1'b0, 0, '0);
        rd_check("R6", 19, 32'h80);
        wr(13, 32'd7);
        rd_check("R4", 19, 32'h0);
        // R5: write-one-to-clear words
        step(1'b0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, '0);
        wr(15, 32'h0000_FFFF);
        rd_check("R5", 15, 32'hFFFF_0000);
        wr(15, 32'hFFFF_FFFF);
        wr(14, 32'hFFFF_FFFF);
        wr(18, 32'hFFFF_FFFF);
        wr(19, 32'hFFFF_FFFF);
        rd_check("R5", 14, 32'h0);
        // R8, R9, R10: error capture, hold and clear
        step(1'b0, 0, 0, '0, '0, 1'b1, 33, 16'hFFFF);
        rd_check("R8", 1, 32'h8000_E1FF);
        rd_check("R8", 16, 32'h2);
        step(1'b0, 0, 0, '0, '0, 1'b1, 5, 16'h0001);
        rd_check("R9", 1, 32'h8000_E1FF);
        rd_check("R9", 17, 32'h20);
        step(1'b1, 1, 0, '0, '0, 1'b1, 2, 16'h4000);
        rd_check("R10", 1, 32'h8000_4200);
        wr(1, 32'h0);
        rd_check("R10", 1, 32'h0);
        // R12: masking by error-interrupt enable
        wr(17, 32'hFFFF_FFFF);
        wr(16, 32'hFFFF_FFFF);
        wr(4, 32'h0);
        step(1'b0, 0, 0, '0, '0, 1'b1, 9, '0);
        check("R12", {63'h0, irq}, 64'h0);
        wr(8, 32'd9);
        check("R12", {63'h0, irq}, 64'h1);
        // R11: control word
        wr(0, 32'hFFFF_FFFF);
        rd_check("R11", 0, 32'h8000_000C);
        wr(25, 32'hFFFF_FFFF);
        // R7: start strobe
        wr(12, 32'd45);
        check("R7", start_pulse, 64'h0000_2000_0000_0000);

        for (int i = 0; i < 3000; i++) begin
            bit we;
            int a;
            logic [31:0] d;
            logic [63:0] hi, hd;
            bit ee;
            we = ($urandom_range(0, 3) != 0);
            a = $urandom_range(0, 21);
            case ($urandom_range(0, 3))
                0: d = 32'hFFFF_FFFF;
                1: d = 32'($urandom_range(0, 255));
                default: d = $urandom;
            endcase
            hi = ($urandom_range(0, 3) == 0) ? {$urandom & $urandom, $urandom & $urandom} : '0;
            hd = ($urandom_range(0, 3) == 0) ? {$urandom & $urandom, $urandom & $urandom} : '0;
            ee = ($urandom_range(0, 7) == 0);
            step(we, a, d, hi, hd, ee, $urandom_range(0, 63), 16'($urandom));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule